// File: doc/BRIEF.md
# Broadcast interrupt acknowledge tracker

This block keeps the books for a single edge-triggered interrupt source that is sent to several destination processors at once. When a delivery is accepted, it stores which destinations took the interrupt in a per-destination bitmap. It also sets a pending count to the number of destinations that took it. As each destination later signals end-of-interrupt, that destination's bit is cleared and the count drops by one.

While any acknowledgement is still owed, the block raises `coalesced`. The interrupt source uses this flag to know that a new assertion must be folded into the outstanding one instead of being delivered again. Each destination's owed bit can also be corrected individually through a restore port, or the whole bitmap can be rebuilt from a snapshot of the destinations' current pending state. The actual message delivery happens outside this block.

Top module: `ack_tracker`

## Requirements
- R1: After `rst_n` is low, or one cycle after `clr` is high, the count is 0 and `coalesced` is 0. `clr` takes precedence over every other input in that cycle.
- R2: A delivery strobe with `dlv_ok`=1 that is accepted loads `dlv_map` as the owed bitmap. The count becomes the number of ones in `dlv_map`, visible on the next cycle.
- R3: An accepted delivery with `dlv_ok`=0 (failed delivery) leaves the count at 0 and the bitmap empty.
- R4: A delivery strobe is accepted only when the count is exactly 0. Otherwise it is ignored and the count is unchanged by it.
- R5: An EOI from destination `eoi_id` whose owed bit is set clears that bit and lowers the count by one. An EOI from a destination whose bit is clear changes nothing, so a repeated EOI has no effect.
- R6: `coalesced` is 1 exactly when the count is nonzero.
- R7: A restore report (`rs_vld`, `rs_id`, `rs_pend`) changes state only when `rs_pend` differs from the stored bit. The bit is then set with the count incremented, or cleared with the count decremented.
- R8: A rebuild strobe replaces the bitmap with `pend_now` and the count with its number of ones. The same rebuild happens automatically if a decrement would take the count below zero.
- R9: In one cycle at most one update happens, with priority `clr`, then rebuild, then accepted delivery, then EOI, then restore.
- R10: The count never exceeds `N_DEST`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of bitmap and count |
| dlv_vld | input | 1 | Delivery strobe |
| dlv_ok | input | 1 | Delivery succeeded (0 = failed) |
| dlv_map | input | N_DEST | Destinations that accepted the delivery |
| eoi_vld | input | 1 | End-of-interrupt strobe |
| eoi_id | input | IW | Destination sending the EOI |
| rs_vld | input | 1 | Restore report strobe |
| rs_id | input | IW | Destination being restored |
| rs_pend | input | 1 | Whether that destination still has the vector pending |
| rbld | input | 1 | Rebuild bitmap and count from `pend_now` |
| pend_now | input | N_DEST | Current per-destination pending status |
| coalesced | output | 1 | Acknowledgement still outstanding |
| pend_cnt | output | CW | Number of outstanding acknowledgements |

## Verification
Deliveries are driven with a sparse bitmap, a full bitmap for the maximum count, and a failed delivery. These separate a correct population count from a stuck or saturated one. EOIs are sent from owed destinations, from never-owed destinations and as repeats, which shows whether the bitmap really gates the decrement. Restores that agree and disagree with the stored bit, a rebuild from a snapshot, and colliding strobes in one cycle check the update priority and the change-only behaviour of restore.

// File: rtl/ack_tracker.sv
module ack_tracker #(
  parameter  int N_DEST = 8,
  localparam int IW = (N_DEST > 1) ? $clog2(N_DEST) : 1,
  localparam int CW = $clog2(N_DEST) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              dlv_vld,
  input  logic              dlv_ok,
  input  logic [N_DEST-1:0] dlv_map,
  input  logic              eoi_vld,
  input  logic [IW-1:0]     eoi_id,
  input  logic              rs_vld,
  input  logic [IW-1:0]     rs_id,
  input  logic              rs_pend,
  input  logic              rbld,
  input  logic [N_DEST-1:0] pend_now,
  output logic              coalesced,
  output logic [CW-1:0]     pend_cnt
);

  function automatic logic [CW-1:0] ones(input logic [N_DEST-1:0] v);
    logic [CW-1:0] s;
    s = '0;
    for (int i = 0; i < N_DEST; i++) s = s + CW'(v[i]);
    return s;
  endfunction

  logic [N_DEST-1:0] map_q;
  logic [CW-1:0]     cnt_q;

  wire eoi_ok   = int'(eoi_id) < N_DEST;
  wire rs_ok    = int'(rs_id) < N_DEST;
  wire eoi_hit  = eoi_ok && map_q[eoi_id];
  wire rs_old   = rs_ok && map_q[rs_id];
  wire cnt_zero = (cnt_q == '0);
  wire dlv_take = dlv_vld && cnt_zero;
  wire eoi_dec  = eoi_vld && eoi_hit;
  wire rs_chg   = !eoi_vld && rs_vld && rs_ok && (rs_pend != rs_old);
  wire rs_dec   = rs_chg && !rs_pend;
  wire underrun = !dlv_take && (eoi_dec || rs_dec) && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      map_q <= '0;
      cnt_q <= '0;
    end else if (rbld || underrun) begin
      map_q <= pend_now;
      cnt_q <= ones(pend_now);
    end else if (dlv_take) begin
      map_q <= dlv_ok ? dlv_map : '0;
      cnt_q <= dlv_ok ? ones(dlv_map) : '0;
    end else if (eoi_vld) begin
      if (eoi_hit) begin
        map_q[eoi_id] <= 1'b0;
        cnt_q         <= cnt_q - 1'b1;
      end
    end else if (rs_chg) begin
      map_q[rs_id] <= rs_pend;
      cnt_q        <= rs_pend ? cnt_q + 1'b1 : cnt_q - 1'b1;
    end
  end

  assign coalesced = !cnt_zero;
  assign pend_cnt  = cnt_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pend_cnt == '0 && !coalesced)); // R1
  AST_DELIVER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_vld && dlv_ok && pend_cnt == '0 && !clr && !rbld) |=>
      (int'(pend_cnt) == $countones($past(dlv_map)))); // R2
  AST_FAILED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_vld && !dlv_ok && pend_cnt == '0 && !clr && !rbld) |=> (pend_cnt == '0)); // R3
  AST_EOI_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_vld && !eoi_hit && !clr && !rbld && !(dlv_vld && pend_cnt == '0)) |=>
      $stable(pend_cnt)); // R5
  AST_EOI_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_vld && eoi_hit && pend_cnt != '0 && !clr && !rbld) |=>
      (pend_cnt == $past(pend_cnt) - 1'b1)); // R5
  AST_REBUILD: assert property (@(posedge clk) disable iff (!rst_n)
    (rbld && !clr) |=> (int'(pend_cnt) == $countones($past(pend_now)))); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend_cnt) <= N_DEST); // R10

endmodule

// File: tb/ack_tracker_bench.sv
module ack_tracker_bench;
  localparam int N  = 8;
  localparam int IW = 3;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0, clr = 0;
  logic dlv_vld = 0, dlv_ok = 0;
  logic [N-1:0] dlv_map = '0;
  logic eoi_vld = 0;
  logic [IW-1:0] eoi_id = '0;
  logic rs_vld = 0, rs_pend = 0;
  logic [IW-1:0] rs_id = '0;
  logic rbld = 0;
  logic [N-1:0] pend_now = '0;
  logic coalesced;
  logic [CW-1:0] pend_cnt;

  int total = 0, bad = 0;

  ack_tracker #(.N_DEST(N)) u_ack_tracker (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .dlv_vld(dlv_vld), .dlv_ok(dlv_ok), .dlv_map(dlv_map),
    .eoi_vld(eoi_vld), .eoi_id(eoi_id),
    .rs_vld(rs_vld), .rs_id(rs_id), .rs_pend(rs_pend),
    .rbld(rbld), .pend_now(pend_now),
    .coalesced(coalesced), .pend_cnt(pend_cnt)
  );

  always #5 clk = ~clk;

  typedef struct { int cnt; string req; } exp_t;
  exp_t q[$];
  logic [N-1:0] m_map = '0;
  int m_cnt = 0;

  // Reference model built from the requirements, then queued for the monitor.
  task automatic go(input string req);
    exp_t e;
    if (clr) begin
      m_map = '0; m_cnt = 0;
    end else if (rbld) begin
      m_map = pend_now; m_cnt = $countones(pend_now);
    end else if (dlv_vld && m_cnt == 0) begin
      m_map = dlv_ok ? dlv_map : '0;
      m_cnt = dlv_ok ? $countones(dlv_map) : 0;
    end else if (eoi_vld) begin
      if (m_map[eoi_id]) begin m_map[eoi_id] = 0; m_cnt--; end
    end else if (rs_vld && rs_pend != m_map[rs_id]) begin
      m_map[rs_id] = rs_pend;
      m_cnt = rs_pend ? m_cnt + 1 : m_cnt - 1;
    end
    e.cnt = m_cnt; e.req = req;
    q.push_back(e);
    @(negedge clk);
    clr = 0; dlv_vld = 0; dlv_ok = 0; eoi_vld = 0; rs_vld = 0; rbld = 0;
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (int'(pend_cnt) != e.cnt || coalesced != (e.cnt != 0)) begin
        bad++;
        $display("FAIL %s: cnt=%0d coal=%0b expected cnt=%0d coal=%0b",
                 e.req, pend_cnt, coalesced, e.cnt, e.cnt != 0);
      end
    end
  end

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    total++;
    if (pend_cnt != 0 || coalesced) begin
      bad++;
      $display("FAIL R1 reset: cnt=%0d coal=%0b expected cnt=0 coal=0", pend_cnt, coalesced);
    end
    rst_n = 1;
    @(negedge clk);

    dlv_vld = 1; dlv_ok = 1; dlv_map = 8'b1011_0001; go("R2 sparse delivery, R6 coalesced");
    dlv_vld = 1; dlv_ok = 1; dlv_map = 8'hFF; go("R4 delivery while pending");
    eoi_vld = 1; eoi_id = 3'd1; go("R5 stray eoi");
    eoi_vld = 1; eoi_id = 3'd0; go("R5 owed eoi");
    eoi_vld = 1; eoi_id = 3'd0; go("R5 repeat eoi");
    eoi_vld = 1; eoi_id = 3'd4; go("R5 eoi 4");
    eoi_vld = 1; eoi_id = 3'd5; go("R5 eoi 5");
    eoi_vld = 1; eoi_id = 3'd7; go("R5 last eoi, R6 coalesced drops");
    dlv_vld = 1; dlv_ok = 0; dlv_map = 8'hFF; go("R3 failed delivery");
    dlv_vld = 1; dlv_ok = 1; dlv_map = 8'hFF; go("R2 full delivery, R10 max count");
    rs_vld = 1; rs_id = 3'd2; rs_pend = 1; go("R7 restore agrees");
    rs_vld = 1; rs_id = 3'd2; rs_pend = 0; go("R7 restore clears");
    rs_vld = 1; rs_id = 3'd2; rs_pend = 1; go("R7 restore sets");
    clr = 1; dlv_vld = 1; dlv_ok = 1; dlv_map = 8'h0F; go("R1 clear, R9 clr over delivery");
    rs_vld = 1; rs_id = 3'd3; rs_pend = 1; go("R7 restore from empty");
    rbld = 1; pend_now = 8'b0110_0000; eoi_vld = 1; eoi_id = 3'd3; go("R8 rebuild, R9 over eoi");
    eoi_vld = 1; eoi_id = 3'd6; rs_vld = 1; rs_id = 3'd0; rs_pend = 1; go("R9 eoi over restore");
    eoi_vld = 1; eoi_id = 3'd5; go("R5 drain");
    dlv_vld = 1; dlv_ok = 1; dlv_map = 8'b0000_0110; eoi_vld = 1; eoi_id = 3'd1; go("R9 delivery over eoi");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule